// File: doc/BRIEF.md
# Borrow-Compare ALU

A purely combinational arithmetic unit for a small register-based processor. It takes two operands read from the register file (`opa_i` from the first source register, `opb_i` from the second) and a 3-bit operation code. It returns a result word and a flag that marks a zero result. There is no clock: both outputs follow the inputs directly.

The unit has three operations: wrapping addition, wrapping subtraction, and an unsigned less-than compare. The compare does not use a separate comparator. It takes the borrow out of the shared subtractor and widens it with zeros to the data width. The sum, the difference and the widened borrow all feed one multiplexer, which sits at the output. The zero detector watches the output of that multiplexer. The operation code has more encodings than the three operations use, so it can grow later. Each unused encoding gives a zero result.

Top module: `alu_top`

## Requirements
- R1: With `op_i` = 3'b000, `res_o` equals (`opa_i` + `opb_i`) modulo 2^DW, and the carry out of the top bit is discarded.
- R2: With `op_i` = 3'b001, `res_o` equals (`opa_i` - `opb_i`) modulo 2^DW, and it wraps when `opb_i` > `opa_i`.
- R3: With `op_i` = 3'b010, `res_o` is 1 when `opa_i` < `opb_i` as unsigned numbers and 0 otherwise, and bits DW-1..1 of the result are always 0.
- R4: With `op_i` = 3'b010 and equal operands, `res_o` is 0.
- R5: Every `op_i` code from 3'b011 to 3'b111 gives `res_o` = 0, whatever the operands are.
- R6: `zero_o` is 1 exactly when `res_o` is all zeros, in every mode.
- R7: Both outputs are combinational. They settle after an input change without any clock edge, and with all inputs at zero they read `res_o` = 0 and `zero_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | DW | First operand (first source register value) |
| opb_i | input | DW | Second operand (second source register value) |
| op_i | input | 3 | Operation code: 000 add, 001 subtract, 010 borrow compare, others reserved |
| res_o | output | DW | Selected result |
| zero_o | output | 1 | High when `res_o` is zero |

## Verification
The zero flag and the arithmetic result are always produced together, so the cases of interest are those where one operation drives the flag high. Three operations can do this: a subtract of equal operands, an add that wraps to exactly 2^DW, and a compare with `opa_i` >= `opb_i`. The reserved codes also force the flag high. The bench reaches all of these cases with an exhaustive sweep of every operand pair and every code on a 4-bit instance, and with chosen edge values on the default 16-bit instance. For each combination it works out the result and the flag by arithmetic and compares both against the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_BRW = 3'b010
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] diff_o,
  output logic          borrow_o
);
  logic [DW:0] sum_ext, diff_ext;

  always_comb begin
    sum_ext  = {1'b0, a_i} + {1'b0, b_i};
    diff_ext = {1'b0, a_i} - {1'b0, b_i};
  end

  // carry dropped on purpose: add wraps
  logic unused_carry;
  assign unused_carry = sum_ext[DW];

  assign sum_o    = sum_ext[DW-1:0];
  assign diff_o   = diff_ext[DW-1:0];
  assign borrow_o = diff_ext[DW];
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
  import alu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   sum_i,
  input  logic [DW-1:0]   diff_i,
  input  logic            borrow_i,
  output logic [DW-1:0]   res_o
);
  logic [DW-1:0] brw_ext;
  assign brw_ext = {{(DW-1){1'b0}}, borrow_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = sum_i;
      OP_SUB:  res_o = diff_i;
      OP_BRW:  res_o = brw_ext;
      default: res_o = '0;  // reserved codes
    endcase
  end
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] val_i,
  output logic          zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic [OP_W-1:0] op_i,
  output logic [DW-1:0]   res_o,
  output logic            zero_o
);
  logic [DW-1:0] sum, diff;
  logic          borrow;

  alu_addsub #(.DW(DW)) i_addsub (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sum_o   (sum),
    .diff_o  (diff),
    .borrow_o(borrow)
  );

  alu_out_mux #(.DW(DW)) i_out_mux (
    .op_i    (op_i),
    .sum_i   (sum),
    .diff_i  (diff),
    .borrow_i(borrow),
    .res_o   (res_o)
  );

  alu_zero_det #(.DW(DW)) i_zero_det (
    .val_i (res_o),
    .zero_o(zero_o)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic [DW-1:0]   opa_i,
  input logic [DW-1:0]   opb_i,
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   res_o,
  input logic            zero_o
);
  always_comb begin
    if (op_i == 3'b000)
      assert_add_wrap_R1: assert (res_o == DW'(opa_i + opb_i));
    if (op_i == 3'b001)
      assert_sub_wrap_R2: assert (res_o == DW'(opa_i - opb_i));
    if (op_i == 3'b010) begin
      assert_brw_lt_R3: assert (res_o[0] == (opa_i < opb_i));
      assert_brw_ext_R3: assert (res_o[DW-1:1] == '0);
      if (opa_i == opb_i)
        assert_brw_eq_R4: assert (res_o == '0);
    end
    if (op_i > 3'b010)
      assert_spare_zero_R5: assert (res_o == '0);
    assert_zero_flag_R6: assert (zero_o == (res_o == '0));
  end
endmodule

bind alu_top alu_checker #(.DW(DW)) i_alu_checker (
  .opa_i (opa_i),
  .opb_i (opb_i),
  .op_i  (op_i),
  .res_o (res_o),
  .zero_o(zero_o)
);

// File: tb/test_alu_top.sv
module test_alu_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // 16-bit default instance
  logic [15:0] a16, b16, r16;
  logic [2:0]  op16;
  logic        z16;
  alu_top i_alu_top (
    .opa_i(a16), .opb_i(b16), .op_i(op16), .res_o(r16), .zero_o(z16)
  );

  // 4-bit instance for exhaustive sweep
  logic [3:0] a4, b4, r4;
  logic [2:0] op4;
  logic       z4;
  alu_top #(.DW(4)) i_alu_top_n4 (
    .opa_i(a4), .opb_i(b4), .op_i(op4), .res_o(r4), .zero_o(z4)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R5";
    endcase
  endfunction

  function automatic int exp_res(input int op, input int a, input int b, input int w);
    int m;
    m = (1 << w) - 1;
    case (op)
      0: return (a + b) & m;
      1: return (a - b) & m;
      2: return (a < b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run16(input int op, input int a, input int b);
    int e;
    @(posedge clk);
    op16 = 3'(op); a16 = 16'(a); b16 = 16'(b);
    @(negedge clk);
    e = exp_res(op, a, b, 16);
    check(tag_of(op), int'(r16), e);
    check("R6", int'(z16), (e == 0) ? 1 : 0);
    if (op == 2 && a == b) check("R4", int'(r16), 0);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    a16 = '0; b16 = '0; op16 = '0;
    a4 = '0; b4 = '0; op4 = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R7: idle inputs, no clocking needed by DUT
    check("R7", int'(r16), 0);
    check("R7", int'(z16), 1);

    // R7: combinational response between clock edges
    #1; a16 = 16'd5; b16 = 16'd7; op16 = 3'b000;
    #1; check("R7", int'(r16), 12);
    check("R7", int'(z16), 0);

    // default-width corner values
    run16(0, 16'hFFFF, 16'h0001);   // R1 wrap to zero
    run16(0, 16'h8000, 16'h8000);
    run16(0, 16'h1234, 16'h4321);
    run16(1, 16'h0000, 16'h0001);   // R2 wrap
    run16(1, 16'hABCD, 16'hABCD);
    run16(1, 16'h8000, 16'h7FFF);
    run16(2, 16'h7FFF, 16'h8000);   // R3 unsigned, not signed
    run16(2, 16'h8000, 16'h7FFF);
    run16(2, 16'hFFFE, 16'hFFFF);
    run16(2, 16'h4242, 16'h4242);   // R4
    run16(2, 0, 0);
    for (int op = 3; op < 8; op++) run16(op, 16'hFFFF, 16'h0001); // R5

    // exhaustive 4-bit sweep: R1..R6
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          int e;
          @(posedge clk);
          op4 = 3'(op); a4 = 4'(a); b4 = 4'(b);
          @(negedge clk);
          e = exp_res(op, a, b, 4);
          check(tag_of(op), int'(r4), e);
          check("R6", int'(z4), (e == 0) ? 1 : 0);
          if (op == 2 && a == b) check("R4", int'(r4), 0);
        end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule